// File: doc/BRIEF.md
# Pulse programming sequencer

This block writes a contiguous range of bytes into a byte-wide programmable ROM that is written by timed program pulses. For every address it takes the wanted byte from a data source and sets up the ROM's address, data and enables. It then fires a program pulse of fixed width and reads the byte back. If the read-back matches, it moves to the next address. Otherwise it pulses again, up to a bounded number of attempts per byte. The raised supplies are requested through two digital select outputs and are held on for the whole programming phase.

When the last address of the range has been programmed, the supply selects drop back to nominal. The sequencer then reads every byte of the range again, from the first address, and compares it with the data source. A run ends with `done` high and exactly one of `pass` or `fail` high. On a failure, `fail_addr` holds the offending address. All microsecond windows are converted to clock cycles from a cycles-per-microsecond parameter.

Top module: `burn_sequencer`

## Requirements
- R1: While reset is held and after it is released, the block is idle: `dev_ce_n`, `dev_oe_n` and `dev_pgm_n` are 1; `dev_dq_oe`, `vcc_hi`, `vpp_hi`, `busy`, `done`, `pass` and `fail` are 0.
- R2: Every program pulse holds `dev_pgm_n` at 0 for exactly PULSE_US*CYC_PER_US cycles. During the pulse, `dev_ce_n`=0, `dev_oe_n`=1, `vcc_hi`=`vpp_hi`=1 and `dev_dq_oe`=1, and `dev_dq_out` carries the source byte for `dev_addr`.
- R3: The address, data, data drive, chip enable and output enable are unchanged for at least SETUP_US*CYC_PER_US cycles before `dev_pgm_n` falls. Data, address and data drive stay unchanged for at least HOLD_US*CYC_PER_US cycles after it rises.
- R4: After every pulse the byte is read back with `dev_oe_n`=0, `dev_ce_n`=0, `dev_pgm_n`=1 and `dev_dq_oe`=0 for exactly RD_WAIT+1 cycles, and the sample is taken in the last of them. Addresses are visited in ascending order from the first to the last address.
- R5: An address keeps receiving pulses until its read-back matches, and the attempt count starts again at zero for each address. A byte that first matches after its MAX_PULSES-th pulse is accepted. A byte that already holds the wanted value still receives one pulse.
- R6: If a byte still mismatches after MAX_PULSES pulses, the run ends at once: `done`=1, `fail`=1 and `fail_addr` is that address. No further pulses are fired, no final pass runs, and the supply selects are 0.
- R7: After the last address is programmed, `vcc_hi` and `vpp_hi` return to 0. Every address from the first to the last is read once more and compared with the source; `dev_pgm_n` stays 1 throughout. A mismatch ends the run with `fail`=1 and `fail_addr` at that address; if all bytes match, the run ends with `pass`=1.
- R8: A `start` pulse while `busy`=1 has no effect on the running range, and no address of the range it carries is touched.
- R9: `done`, `pass`, `fail` and `fail_addr` hold their values until the next accepted `start`, which clears `done` on the next cycle. `pass` and `fail` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when idle) |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range |
| src_addr | output | ADDR_W | Address presented to the data source |
| src_data | input | DATA_W | Wanted byte for `src_addr`, same cycle |
| dev_addr | output | ADDR_W | ROM address |
| dev_dq_out | output | DATA_W | Data driven toward the ROM |
| dev_dq_oe | output | 1 | Drive enable for `dev_dq_out` |
| dev_dq_in | input | DATA_W | Data read from the ROM |
| dev_ce_n | output | 1 | ROM chip enable, active low |
| dev_oe_n | output | 1 | ROM output enable, active low |
| dev_pgm_n | output | 1 | ROM program strobe, active low |
| vcc_hi | output | 1 | Select raised core supply |
| vpp_hi | output | 1 | Select programming supply |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every byte matching |
| fail | output | 1 | Run finished with a failure |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
The bench models the ROM so that each address needs its own number of pulses before its bits clear. The needs vary from one to four, with one byte needing exactly the pulse limit and one needing more than the limit. This separates a correct per-address retry reset and limit check from off-by-one or missing-reset faults. A byte whose wanted value equals the erased value shows that the first pulse is always given. A bit flipped between the two phases is caught only by the final pass, which separates that pass from the per-pulse read-back. A `start` injected mid-run with a different range shows that `start` is ignored while busy, and a one-address range covers the case where the first address is also the last.

// File: rtl/burn_pkg.sv
package burn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PLOAD   = 3'd1,
    ST_SETUP   = 3'd2,
    ST_PULSE   = 3'd3,
    ST_HOLD    = 3'd4,
    ST_PVERIFY = 3'd5,
    ST_FLOAD   = 3'd6,
    ST_FREAD   = 3'd7
  } burn_state_t;

  // microsecond window to clock cycles
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/burn_retry.sv
module burn_retry #(
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic at_limit
);
  localparam int unsigned RW = $clog2(MAX_PULSES + 1);
  logic [RW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (bump) count <= count + RW'(1);
  end

  assign at_limit = (count >= RW'(MAX_PULSES));

  // R5
  retry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= RW'(MAX_PULSES));
  // R6
  retry_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clr) |-> !bump);
endmodule

// File: rtl/burn_addr_walk.sv
module burn_addr_walk #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [AW-1:0] first_in,
  input  logic [AW-1:0] last_in,
  input  logic          rewind,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] bound,
  output logic          is_last
);
  logic [AW-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      bound   <= '0;
      addr    <= '0;
    end else if (init) begin
      first_q <= first_in;
      bound   <= last_in;
      addr    <= first_in;
    end else if (rewind) begin
      addr    <= first_q;
    end else if (step) begin
      addr    <= addr + AW'(1);
    end
  end

  assign is_last = (addr >= bound);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (addr < bound));
endmodule

// File: rtl/burn_sequencer.sv
module burn_sequencer
  import burn_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CYC_PER_US = 4,
  parameter int unsigned PULSE_US   = 100,
  parameter int unsigned SETUP_US   = 2,
  parameter int unsigned HOLD_US    = 2,
  parameter int unsigned RD_WAIT    = 3,
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dq_out,
  output logic              dev_dq_oe,
  input  logic [DATA_W-1:0] dev_dq_in,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_pgm_n,
  output logic              vcc_hi,
  output logic              vpp_hi,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int unsigned PW_CYC = us_to_cycles(PULSE_US, CYC_PER_US);
  localparam int unsigned SU_CYC = us_to_cycles(SETUP_US, CYC_PER_US);
  localparam int unsigned HD_CYC = us_to_cycles(HOLD_US,  CYC_PER_US);
  localparam int unsigned RD_CYC = RD_WAIT + 1;
  localparam int unsigned TW     = $clog2(max4(PW_CYC, SU_CYC, HD_CYC, RD_CYC) + 1);

  burn_state_t st, nxt;

  logic              tmr_ld, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              w_init, w_rewind, w_step, w_last;
  logic [ADDR_W-1:0] w_addr, w_bound;
  logic              r_clr, r_bump, r_limit;
  logic              fin_pass, fin_fail, accept;
  logic [DATA_W-1:0] want_q;
  logic              rd_match, prog_phase, final_phase;

  burn_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_done));

  burn_addr_walk #(.AW(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .init(w_init), .first_in(start_addr), .last_in(end_addr),
    .rewind(w_rewind), .step(w_step), .addr(w_addr), .bound(w_bound), .is_last(w_last));

  burn_retry #(.MAX_PULSES(MAX_PULSES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(r_clr), .bump(r_bump), .at_limit(r_limit));

  assign rd_match = (dev_dq_in == want_q);
  assign accept   = (st == ST_IDLE) && start;

  always_comb begin
    nxt      = st;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    w_init   = 1'b0;
    w_rewind = 1'b0;
    w_step   = 1'b0;
    r_clr    = 1'b0;
    r_bump   = 1'b0;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt    = ST_PLOAD;
        w_init = 1'b1;
      end
      ST_PLOAD: begin
        nxt     = ST_SETUP;
        tmr_ld  = 1'b1;
        tmr_val = TW'(SU_CYC - 1);
        r_clr   = 1'b1;
      end
      ST_SETUP: if (tmr_done) begin
        nxt     = ST_PULSE;
        tmr_ld  = 1'b1;
        tmr_val = TW'(PW_CYC - 1);
        r_bump  = 1'b1;
      end
      ST_PULSE: if (tmr_done) begin
        nxt     = ST_HOLD;
        tmr_ld  = 1'b1;
        tmr_val = TW'(HD_CYC - 1);
      end
      ST_HOLD: if (tmr_done) begin
        nxt     = ST_PVERIFY;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RD_WAIT);
      end
      ST_PVERIFY: if (tmr_done) begin
        if (rd_match) begin
          if (w_last) begin
            nxt      = ST_FLOAD;
            w_rewind = 1'b1;
          end else begin
            nxt    = ST_PLOAD;
            w_step = 1'b1;
          end
        end else if (r_limit) begin
          nxt      = ST_IDLE;
          fin_fail = 1'b1;
        end else begin
          nxt     = ST_SETUP;
          tmr_ld  = 1'b1;
          tmr_val = TW'(SU_CYC - 1);
        end
      end
      ST_FLOAD: begin
        nxt     = ST_FREAD;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RD_WAIT);
      end
      ST_FREAD: if (tmr_done) begin
        if (!rd_match) begin
          nxt      = ST_IDLE;
          fin_fail = 1'b1;
        end else if (w_last) begin
          nxt      = ST_IDLE;
          fin_pass = 1'b1;
        end else begin
          nxt    = ST_FLOAD;
          w_step = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      want_q <= '0;
    else if (st == ST_PLOAD || st == ST_FLOAD)       want_q <= src_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (accept) begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (fin_pass) begin
      done <= 1'b1;
      pass <= 1'b1;
    end else if (fin_fail) begin
      done      <= 1'b1;
      fail      <= 1'b1;
      fail_addr <= w_addr;
    end
  end

  assign prog_phase  = (st == ST_PLOAD) || (st == ST_SETUP) || (st == ST_PULSE) ||
                       (st == ST_HOLD)  || (st == ST_PVERIFY);
  assign final_phase = (st == ST_FLOAD) || (st == ST_FREAD);

  assign busy       = (st != ST_IDLE);
  assign vcc_hi     = prog_phase;
  assign vpp_hi     = prog_phase;
  assign dev_ce_n   = !(prog_phase || final_phase);
  assign dev_oe_n   = !((st == ST_PVERIFY) || (st == ST_FREAD));
  assign dev_pgm_n  = (st != ST_PULSE);
  assign dev_dq_oe  = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
  assign dev_dq_out = want_q;
  assign dev_addr   = w_addr;
  assign src_addr   = w_addr;

  // R2
  pulse_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pgm_n |-> (!dev_ce_n && dev_oe_n && vcc_hi && vpp_hi && dev_dq_oe));
  // R3
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_pgm_n) |-> ($stable(dev_addr) && $stable(dev_dq_out) && $stable(dev_oe_n)));
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pgm_n) |-> (dev_dq_oe && $stable(dev_dq_out) && $stable(dev_addr)));
  // R4
  read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe_n |-> (!dev_dq_oe && dev_pgm_n && !dev_ce_n));
  // R7
  final_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_ce_n && !vpp_hi) |-> (!vcc_hi && dev_pgm_n));
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vpp_hi && !vcc_hi && dev_ce_n));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(w_bound));
  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));
endmodule

// File: tb/burn_sequencer_bench.sv
module burn_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, CPU = 1, PUS = 100, SUS = 2, HUS = 2, RDW = 3, MAXP = 10;
  localparam int PW = PUS * CPU, SU = SUS * CPU, HD = HUS * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0, src_addr, dev_addr, fail_addr;
  logic [DW-1:0] src_data, dev_dq_out, dev_dq_in;
  logic dev_dq_oe, dev_ce_n, dev_oe_n, dev_pgm_n, vcc_hi, vpp_hi, busy, done, pass, fail;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [256];
  int pulses [256];
  bit corrupt_en = 0;
  int corrupt_addr = 0;
  int prog_q[$], fin_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burn_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CYC_PER_US(CPU), .PULSE_US(PUS),
    .SETUP_US(SUS), .HOLD_US(HUS), .RD_WAIT(RDW), .MAX_PULSES(MAXP)) u_burn_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .end_addr(end_addr),
    .src_addr(src_addr), .src_data(src_data), .dev_addr(dev_addr), .dev_dq_out(dev_dq_out),
    .dev_dq_oe(dev_dq_oe), .dev_dq_in(dev_dq_in), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
    .dev_pgm_n(dev_pgm_n), .vcc_hi(vcc_hi), .vpp_hi(vpp_hi), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .fail_addr(fail_addr));

  function automatic logic [7:0] tb_data(input int a);
    if (a == 6) return 8'hFF;
    return 8'((a * 37 + 5) % 256);
  endfunction

  function automatic int tb_need(input int a);
    if (a == 9)  return 10;
    if (a == 21) return 11;
    return (a % 4) + 1;
  endfunction

  assign src_data  = tb_data(int'(src_addr));
  assign dev_dq_in = (!dev_ce_n && !dev_oe_n) ? mem[dev_addr] : 8'hFF;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural ROM and protocol monitor, evaluated every clock
  logic [AW+DW+2:0] sig, prev_sig;
  bit prev_pgm = 1, prev_oe = 1, prev_vpp = 0, pulse_ok = 0, hold_on = 0;
  int run = 0, plen = 0, olen = 0, hcnt = 0;
  logic [DW-1:0] lat = '0;
  logic [AW-1:0] lat_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pgm = 1; prev_oe = 1; prev_vpp = 0; run = 0; plen = 0; olen = 0; hold_on = 0;
      prev_sig = '0;
    end else begin
      sig = {dev_addr, dev_dq_out, dev_dq_oe, dev_ce_n, dev_oe_n};
      if (!dev_pgm_n) begin
        if (prev_pgm) begin
          chk(run >= SU, "R3", "setup cycles", run, SU);
          chk(dev_dq_out == tb_data(int'(dev_addr)), "R2", "pulse data",
              int'(dev_dq_out), int'(tb_data(int'(dev_addr))));
          lat = dev_dq_out; lat_addr = dev_addr; plen = 0; pulse_ok = 1;
        end
        plen++;
        if (dev_ce_n || !dev_oe_n || !vcc_hi || !vpp_hi || !dev_dq_oe || dev_addr != lat_addr)
          pulse_ok = 0;
      end else if (!prev_pgm) begin
        chk(plen == PW, "R2", "pulse width", plen, PW);
        chk(pulse_ok, "R2", "levels during pulse", int'(pulse_ok), 1);
        pulses[lat_addr]++;
        if (pulses[lat_addr] >= tb_need(int'(lat_addr))) mem[lat_addr] = mem[lat_addr] & lat;
        hold_on = 1; hcnt = 0;
      end
      if (hold_on) begin
        if (dev_dq_oe && dev_dq_out == lat && dev_addr == lat_addr && dev_pgm_n) hcnt++;
        else begin
          chk(hcnt >= HD, "R3", "hold cycles", hcnt, HD);
          hold_on = 0;
        end
      end
      if (!dev_oe_n) begin
        if (prev_oe) begin
          if (vpp_hi) prog_q.push_back(int'(dev_addr));
          else        fin_q.push_back(int'(dev_addr));
        end
        olen++;
        chk(!dev_dq_oe && dev_pgm_n && !dev_ce_n, "R4", "read bus levels",
            int'({dev_dq_oe, dev_pgm_n, dev_ce_n}), 2);
      end else if (!prev_oe) begin
        chk(olen == RDW + 1, "R4", "read window", olen, RDW + 1);
        olen = 0;
      end
      if (!vpp_hi && !dev_ce_n)
        chk(!vcc_hi && dev_pgm_n, "R7", "final phase levels", int'({vcc_hi, dev_pgm_n}), 1);
      if (corrupt_en && prev_vpp && !vpp_hi) mem[corrupt_addr] = mem[corrupt_addr] ^ 8'h01;
      run      = (sig == prev_sig) ? run + 1 : 1;
      prev_sig = sig;
      prev_pgm = dev_pgm_n;
      prev_oe  = dev_oe_n;
      prev_vpp = vpp_hi;
    end
  end

  function automatic bit same_q(input int a[$], input int b[$]);
    if (a.size() != b.size()) return 0;
    foreach (a[i]) if (a[i] != b[i]) return 0;
    return 1;
  endfunction

  task automatic run_case(input int first, input int last, input int corrupt,
                          input bit poke, input bit later, input string tag);
    int ep[256];
    int eprog[$], efin[$];
    int exp_fail;
    int guard;
    bit exp_pass;
    for (int a = 0; a < 256; a++) begin mem[a] = 8'hFF; pulses[a] = 0; ep[a] = 0; end
    prog_q.delete(); fin_q.delete();
    exp_fail = -1;
    for (int a = first; a <= last; a++) begin
      int p;
      p = (tb_data(a) == 8'hFF) ? 1 : tb_need(a);
      if (p > MAXP) begin
        ep[a] = MAXP;
        for (int k = 0; k < MAXP; k++) eprog.push_back(a);
        exp_fail = a;
        break;
      end
      ep[a] = p;
      for (int k = 0; k < p; k++) eprog.push_back(a);
    end
    if (exp_fail < 0) begin
      for (int a = first; a <= last; a++) begin
        efin.push_back(a);
        if (a == corrupt) begin exp_fail = a; break; end
      end
    end
    exp_pass     = (exp_fail < 0);
    corrupt_en   = (corrupt >= 0);
    corrupt_addr = (corrupt >= 0) ? corrupt : 0;

    @(negedge clk);
    start_addr = AW'(first); end_addr = AW'(last); start = 1;
    @(negedge clk);
    start = 0;
    if (later) chk(!done && busy, "R9", {tag, " done cleared by start"}, int'(done), 0);
    if (poke) begin
      repeat (50) @(negedge clk);
      start_addr = 8'd200; end_addr = 8'd201; start = 1;
      @(negedge clk);
      start = 0; start_addr = AW'(first); end_addr = AW'(last);
    end
    guard = 0;
    while (!done && guard < 100000) begin @(negedge clk); guard++; end

    chk(done, "R9", {tag, " done"}, int'(done), 1);
    chk(pass == exp_pass && fail == !exp_pass, exp_pass ? "R7" : "R6",
        {tag, " pass/fail"}, int'({pass, fail}), exp_pass ? 2 : 1);
    if (!exp_pass)
      chk(int'(fail_addr) == exp_fail, "R6", {tag, " fail_addr"}, int'(fail_addr), exp_fail);
    chk(!vpp_hi && !vcc_hi && dev_ce_n, "R6", {tag, " supplies released"},
        int'({vpp_hi, vcc_hi, dev_ce_n}), 1);
    for (int a = first; a <= last; a++)
      chk(pulses[a] == ep[a], "R5", {tag, " pulses per address"}, pulses[a], ep[a]);
    chk(same_q(prog_q, eprog), "R4", {tag, " read-back order"}, prog_q.size(), eprog.size());
    chk(same_q(fin_q, efin), "R7", {tag, " final pass order"}, fin_q.size(), efin.size());
    if (poke) begin
      chk(pulses[200] == 0 && pulses[201] == 0, "R8", "start ignored: no pulses",
          pulses[200] + pulses[201], 0);
      chk(mem[200] == 8'hFF, "R8", "start ignored: byte untouched", int'(mem[200]), 255);
    end
    repeat (5) @(negedge clk);
    chk(done && pass == exp_pass && !busy, "R9", {tag, " result held"},
        int'({done, pass, busy}), exp_pass ? 6 : 4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(dev_ce_n && dev_oe_n && dev_pgm_n && !dev_dq_oe && !vcc_hi && !vpp_hi,
        "R1", "pins in reset", int'({dev_ce_n, dev_oe_n, dev_pgm_n, dev_dq_oe, vcc_hi, vpp_hi}), 56);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && dev_ce_n && !vpp_hi, "R1", "idle after reset",
        int'({busy, done, pass, fail}), 0);
    run_case(4, 11, -1, 0, 0, "range 4..11");
    run_case(20, 23, -1, 0, 1, "limit exceeded");
    run_case(32, 35, 33, 0, 1, "final mismatch");
    run_case(48, 50, -1, 1, 1, "start while busy");
    run_case(60, 60, -1, 0, 1, "single address");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule